// File: doc/BRIEF.md
# While-Lower Predicate Generator

This block builds a loop-control predicate from two unsigned 64-bit scalars. It takes a running counter value (`base_i`) and an exclusive bound (`limit_i`). Element `i` of the result is active while `base_i + i` is still below `limit_i`. The mask is produced for a chosen element width and for the vector length currently configured. The result is laid out with one predicate bit per vector byte. Software-visible loop code uses it to process the final partial vector of a loop without a scalar tail.

A caller presents the operands with a one-cycle `start_i` strobe. In the next cycle the block returns the mask, a `valid_o` pulse and three condition flags. The flags say whether the first element is active, whether no element is active, and whether the last element inside the active length is active. Between strobes the outputs hold their last values.

Top module: `wl_pred_gen`

## Requirements
- R1: For element index `i` below the element count, element `i` is active exactly when `base_i + i < limit_i`, compared as unsigned values. An active element sets mask bit `i * B`, where `B` is the element width in bytes.
- R2: The active elements always form a run that starts at element 0. Once an element is inactive, every higher element is inactive too.
- R3: `esize_i` selects the element width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. The element count is `16 * vl / B`, where `vl` is the effective number of 128-bit granules.
- R4: Within each active element's byte group, only the lowest mask bit may be set; the other bits of the group are 0. Mask bits at or above byte `16 * vl` are 0.
- R5: When `limit_i <= base_i`, the mask is all zeros.
- R6: `base_i + i` is evaluated without wrapping at 64 bits. A sum that would pass 2^64 - 1 marks its element inactive.
- R7: `first_o` is 1 exactly when element 0 is active.
- R8: `none_o` is 1 exactly when no element is active.
- R9: `last_o` is 1 exactly when the element count is nonzero and the highest-numbered element is active.
- R10: The mask and flags reflect a request on the rising edge that samples `start_i` high. `valid_o` is 1 for exactly the cycle that follows such an edge. Without `start_i`, the mask and flags keep their values.
- R11: While `rst_n` is low, `pred_o`, `valid_o`, `first_o`, `none_o` and `last_o` are all 0.
- R12: A `vl_i` above `MAX_GRAN` is treated as `MAX_GRAN`. A `vl_i` of 0 gives zero elements, so the mask is 0, `none_o` = 1 and `last_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe; operands are sampled when high |
| base_i | input | 64 | Unsigned starting counter value |
| limit_i | input | 64 | Unsigned exclusive bound |
| esize_i | input | 2 | Element width select (1/2/4/8 bytes) |
| vl_i | input | $clog2(MAX_GRAN+1) | Active vector length in 128-bit granules |
| pred_o | output | 16*MAX_GRAN | Predicate mask, one bit per vector byte |
| valid_o | output | 1 | High for the cycle after a request |
| first_o | output | 1 | Element 0 active |
| none_o | output | 1 | No element active |
| last_o | output | 1 | Highest element inside the length is active |

## Verification
The bench targets bounds that sit exactly on, one below and one above the element count, because an off-by-one comparison would drop or add one active element at the run's end and flip `last_o`. It uses bases near 2^64 - 1: a wrapping adder would wrongly reactivate high elements there. It drives `limit_i` equal to and below `base_i`: a signed or reversed subtraction would produce a full mask instead of an empty one. It also sweeps all four element widths, and zero and oversize vector lengths. A design that misplaces the group bit, or lets bits leak past the active length, shows stray mask bits in those cases.

// File: rtl/wl_pkg.sv
package wl_pkg;

  typedef enum logic [1:0] {
    EW_BYTE = 2'd0,
    EW_HALF = 2'd1,
    EW_WORD = 2'd2,
    EW_DBL  = 2'd3
  } elem_w_e;

  localparam int unsigned BYTES_PER_GRAN = 16;

endpackage

// File: rtl/wl_span.sv
module wl_span #(
  parameter int unsigned MAX_GRAN = 4,
  parameter int unsigned GW       = $clog2(MAX_GRAN + 1),
  parameter int unsigned CW       = $clog2(MAX_GRAN * 16 + 1)
) (
  input  logic [63:0]          base_i,
  input  logic [63:0]          limit_i,
  input  logic [GW-1:0]        vl_i,
  input  wl_pkg::elem_w_e      ew_i,
  output logic [CW-1:0]        n_elem_o,
  output logic [CW-1:0]        n_act_o
);
  import wl_pkg::*;

  logic [GW-1:0] vl_eff;
  logic [CW-1:0] bytes_v;
  logic [63:0]   gap;

  always_comb begin
    vl_eff   = (vl_i > GW'(MAX_GRAN)) ? GW'(MAX_GRAN) : vl_i;
    bytes_v  = CW'(vl_eff) * CW'(BYTES_PER_GRAN);
    n_elem_o = bytes_v >> ew_i;
    gap      = (limit_i > base_i) ? (limit_i - base_i) : 64'd0;
    n_act_o  = (gap < {{(64-CW){1'b0}}, n_elem_o}) ? gap[CW-1:0] : n_elem_o;
  end

endmodule

// File: rtl/wl_mask.sv
module wl_mask #(
  parameter int unsigned PBITS = 64,
  parameter int unsigned CW    = $clog2(PBITS + 1)
) (
  input  wl_pkg::elem_w_e    ew_i,
  input  logic [CW-1:0]      n_act_i,
  output logic [PBITS-1:0]   mask_o
);
  import wl_pkg::*;

  for (genvar j = 0; j < PBITS; j++) begin : g_bit
    always_comb begin
      unique case (ew_i)
        EW_BYTE: mask_o[j] = CW'(j) < n_act_i;
        EW_HALF: mask_o[j] = ((j % 2) == 0) && (CW'(j / 2) < n_act_i);
        EW_WORD: mask_o[j] = ((j % 4) == 0) && (CW'(j / 4) < n_act_i);
        default: mask_o[j] = ((j % 8) == 0) && (CW'(j / 8) < n_act_i);
      endcase
    end
  end

endmodule

// File: rtl/wl_pred_gen.sv
module wl_pred_gen #(
  parameter int unsigned MAX_GRAN = 4,
  localparam int unsigned PBITS   = MAX_GRAN * 16,
  localparam int unsigned GW      = $clog2(MAX_GRAN + 1),
  localparam int unsigned CW      = $clog2(PBITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [63:0]       base_i,
  input  logic [63:0]       limit_i,
  input  logic [1:0]        esize_i,
  input  logic [GW-1:0]     vl_i,
  output logic [PBITS-1:0]  pred_o,
  output logic              valid_o,
  output logic              first_o,
  output logic              none_o,
  output logic              last_o
);
  import wl_pkg::*;

  elem_w_e          ew;
  logic [CW-1:0]    n_elem, n_act;
  logic [PBITS-1:0] mask_c;

  logic [PBITS-1:0] pred_d, pred_q;
  logic             vld_d, vld_q;
  logic             fst_d, fst_q;
  logic             non_d, non_q;
  logic             lst_d, lst_q;

  assign ew = elem_w_e'(esize_i);

  wl_span #(.MAX_GRAN(MAX_GRAN), .GW(GW), .CW(CW)) u_span (
    .base_i   (base_i),
    .limit_i  (limit_i),
    .vl_i     (vl_i),
    .ew_i     (ew),
    .n_elem_o (n_elem),
    .n_act_o  (n_act)
  );

  wl_mask #(.PBITS(PBITS), .CW(CW)) u_mask (
    .ew_i    (ew),
    .n_act_i (n_act),
    .mask_o  (mask_c)
  );

  // next state: load on request, otherwise hold
  always_comb begin
    vld_d  = start_i;
    pred_d = pred_q;
    fst_d  = fst_q;
    non_d  = non_q;
    lst_d  = lst_q;
    if (start_i) begin
      pred_d = mask_c;
      fst_d  = (n_act != '0);
      non_d  = (n_act == '0);
      lst_d  = (n_elem != '0) && (n_act == n_elem);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      vld_q  <= 1'b0;
      fst_q  <= 1'b0;
      non_q  <= 1'b0;
      lst_q  <= 1'b0;
    end else begin
      pred_q <= pred_d;
      vld_q  <= vld_d;
      fst_q  <= fst_d;
      non_q  <= non_d;
      lst_q  <= lst_d;
    end
  end

  assign pred_o  = pred_q;
  assign valid_o = vld_q;
  assign first_o = fst_q;
  assign none_o  = non_q;
  assign last_o  = lst_q;

endmodule

// File: rtl/wl_pred_gen_chk.sv
module wl_pred_gen_chk #(
  parameter int unsigned MAX_GRAN = 4,
  localparam int unsigned PBITS   = MAX_GRAN * 16,
  localparam int unsigned GW      = $clog2(MAX_GRAN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [63:0]       base_i,
  input logic [63:0]       limit_i,
  input logic [1:0]        esize_i,
  input logic [GW-1:0]     vl_i,
  input logic [PBITS-1:0]  pred_o,
  input logic              valid_o,
  input logic              first_o,
  input logic              none_o,
  input logic              last_o
);

  function automatic logic [PBITS-1:0] lead_bits(input logic [1:0] es);
    logic [PBITS-1:0] m;
    m = '0;
    for (int j = 0; j < PBITS; j++)
      if ((j % (1 << es)) == 0) m[j] = 1'b1;
    return m;
  endfunction

  // R4
  group_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ((pred_o & ~lead_bits($past(esize_i))) == '0));

  // R5
  empty_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (limit_i <= base_i)) |=> (pred_o == '0));

  // R7
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (first_o == pred_o[0]));

  // R8
  none_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (none_o == (pred_o == '0)));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !(none_o && first_o));

  // R12
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (vl_i == '0)) |=> (none_o && !last_o));

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);

  // R10
  hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(pred_o) && $stable(first_o) && $stable(none_o) && $stable(last_o)));

  // R11
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (pred_o == '0 && !valid_o && !first_o && !none_o && !last_o);
    end
  end

endmodule

bind wl_pred_gen wl_pred_gen_chk #(.MAX_GRAN(MAX_GRAN)) u_chk (.*);

// File: tb/tb_wl_pred_gen.sv
module tb_wl_pred_gen;
  localparam int unsigned MAX_GRAN = 4;
  localparam int unsigned PBITS    = MAX_GRAN * 16;
  localparam int unsigned GW       = $clog2(MAX_GRAN + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [63:0]       base_i, limit_i;
  logic [1:0]        esize_i;
  logic [GW-1:0]     vl_i;
  logic [PBITS-1:0]  pred_o;
  logic              valid_o, first_o, none_o, last_o;

  int unsigned vectors = 0;
  int unsigned errors  = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  wl_pred_gen #(.MAX_GRAN(MAX_GRAN)) dut (.*);

  task automatic chk(input string tag, input logic [PBITS-1:0] act, input logic [PBITS-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected mask from the element rule, one 65-bit sum per element
  function automatic logic [PBITS-1:0] ref_mask(input logic [63:0] b, input logic [63:0] l,
                                                input int vl, input int es, output int n);
    logic [PBITS-1:0] m;
    logic [64:0] s;
    int veff;
    veff = (vl > MAX_GRAN) ? MAX_GRAN : vl;
    n = (veff * 16) / (1 << es);
    m = '0;
    for (int e = 0; e < n; e++) begin
      s = {1'b0, b} + 65'(e);
      if (s < {1'b0, l}) m[e * (1 << es)] = 1'b1;
    end
    return m;
  endfunction

  task automatic run(input logic [63:0] b, input logic [63:0] l, input int vl, input int es,
                     input string tag, input bit hold);
    logic [PBITS-1:0] exp;
    int n;
    logic lst;
    @(negedge clk);
    base_i = b; limit_i = l; vl_i = GW'(vl); esize_i = 2'(es); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    exp = ref_mask(b, l, vl, es, n);
    lst = (n > 0) ? exp[(n - 1) * (1 << es)] : 1'b0;
    chk({tag, " R1 R3 R4 mask"}, pred_o, exp);
    chk("R10 valid", PBITS'(valid_o), PBITS'(1));
    chk("R7 first", PBITS'(first_o), PBITS'(exp[0]));
    chk("R8 none", PBITS'(none_o), PBITS'(exp == '0));
    chk("R9 last", PBITS'(last_o), PBITS'(lst));
    if (hold) begin
      base_i = ~b; limit_i = ~l;
      @(negedge clk);
      chk("R10 hold mask", pred_o, exp);
      chk("R10 valid low", PBITS'(valid_o), '0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int unsigned sd;
    logic [63:0] b, l;
    int d;
    sd = $urandom(32'd2024);
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; limit_i = '0; esize_i = '0; vl_i = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset mask", pred_o, '0);
    chk("R11 reset flags", PBITS'({valid_o, first_o, none_o, last_o}), '0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    run(64'd100, 64'd100, MAX_GRAN, 0, "R5 equal", 1'b1);
    run(64'd500, 64'd7,   MAX_GRAN, 2, "R5 below", 1'b0);
    run(64'd0,   64'd5,   MAX_GRAN, 0, "R2 partial", 1'b1);
    for (int es = 0; es < 4; es++) begin
      int n = (MAX_GRAN * 16) >> es;
      run(64'd40, 64'(40 + n),     MAX_GRAN, es, "R9 exact", 1'b0);
      run(64'd40, 64'(40 + n - 1), MAX_GRAN, es, "R9 one short", 1'b0);
      run(64'd40, 64'(40 + n + 1), MAX_GRAN, es, "R3 one over", 1'b0);
      run(64'd9,  64'd12,          1,        es, "R4 short length", 1'b0);
    end
    run(64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFF, MAX_GRAN, 0, "R6 near top", 1'b0);
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, MAX_GRAN, 3, "R6 at top", 1'b0);
    run(64'd0, 64'd1000, 0, 1, "R12 zero length", 1'b0);
    run(64'd0, 64'd1000, (1 << GW) - 1, 0, "R12 oversize length", 1'b0);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      b = {$urandom, $urandom};
      if (($urandom % 8) == 0) b = 64'hFFFF_FFFF_FFFF_FFFF - 64'($urandom % 70);
      d = int'($urandom % 90) - 10;
      l = b + 64'(signed'(d));
      if (($urandom % 10) == 0) l = {$urandom, $urandom};
      run(b, l, int'($urandom % (1 << GW)), int'($urandom % 4), "R1 random", ($urandom % 4) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule